// File: doc/BRIEF.md
# Bus-Control Port Pin-Function Multiplexer

This block sits between an 8-pin port's pads and the rest of a chip. Each pin can be given to a dedicated bus-control or interrupt function, which then supplies the pin's output value and output enable. Otherwise the pin is a general-purpose I/O pin. A function-select register holds one bit per pin and makes this choice. A direction register sets GPIO pins to input or output. An output latch holds the value that GPIO output pins drive. All three registers sit on a small register bus with a combinational read path.

The two lowest pins can only be inputs. They carry the active-low maskable and non-maskable interrupt requests. The block never drives them, whatever the register settings or dedicated-function inputs are. Their synchronized levels can always be read through the data register, even while they serve as interrupt lines. Every pad input goes through a synchronizer before it reaches the read path, the pin-level outputs or the interrupt outputs.

Top module: `port_func_mux`

## Requirements
- R1: After reset, the direction register reads zero, the function-select register reads its reset default (zero by default), the output latch is zero, and no pad output enable is asserted.
- R2: A GPIO pin (function-select bit 0) whose direction bit is 1 asserts its pad output enable and drives the output latch bit.
- R3: A GPIO pin whose direction bit is 0 keeps its pad output enable low.
- R4: A pin whose function-select bit is 1 takes its pad output enable and value from the dedicated-function inputs, whatever its direction bit is.
- R5: Pins 1 and 0 never assert a pad output enable, even when the direction, function-select or dedicated-enable inputs ask for it.
- R6: Register address 1 is direction and address 2 is function select. A write to either updates bits 7..2 on the next clock. Bits 1..0 of both ignore writes and read back as zero.
- R7: A read at address 0 returns, per bit, the output latch for a GPIO output pin and the synchronized pad level for any other pin. A pad change shows up in the synchronized level after exactly two clock edges. A write at address 0 loads the output latch.
- R8: Bits 1 and 0 of a data read always return the synchronized pad level. The maskable interrupt request output follows synchronized pin 0 and the non-maskable one follows synchronized pin 1.
- R9: Address 3 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 data, 1 direction, 2 function select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for addr |
| ded_oe | input | 8 | Output enables from the dedicated functions |
| ded_out | input | 8 | Output values from the dedicated functions |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pin_level | output | 8 | Synchronized pad levels for the dedicated functions |
| mirq_n | output | 1 | Maskable interrupt request, active low, from pin 0 |
| nmirq_n | output | 1 | Non-maskable interrupt request, active low, from pin 1 |

## Verification
The bench moves the pins through several setups and checks the output enables and read data in each: all pins GPIO with every direction bit set, a mixed direction mask, and every pin assigned while the dedicated enables are all asserted. The all-set direction pattern shows whether the input-only pins are still masked off. The dedicated pattern shows whether function select overrides direction. Data reads use pad patterns that are the inverse of the latch contents, so a bit returned from the wrong source is caught. One single pad change is sampled one edge and two edges after it happens, which checks the synchronizer depth exactly. Interrupt pin levels are toggled while those pins are assigned, and the unused address is written to check that it has no effect.

// File: rtl/port_mux_pkg.sv
package port_mux_pkg;

    localparam int PW = 8;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_FSEL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PW-1:0] latch;
        logic [PW-1:0] dir;
        logic [PW-1:0] fsel;
    } port_cfg_t;

    typedef struct packed {
        logic [PW-1:0] oe;
        logic [PW-1:0] val;
    } pin_drive_t;

    function automatic logic [PW-1:0] drivable_mask(input int in_only);
        logic [PW-1:0] m;
        for (int i = 0; i < PW; i++) m[i] = (i >= in_only);
        return m;
    endfunction

endpackage

// File: rtl/port_regs.sv
module port_regs
    import port_mux_pkg::*;
#(
    parameter int            IN_ONLY  = 2,
    parameter logic [PW-1:0] FSEL_RST = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic [PW-1:0] wdata,
    output port_cfg_t     cfg
);
    localparam logic [PW-1:0] WMASK = drivable_mask(IN_ONLY);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.latch <= '0;
            cfg.dir   <= '0;
            cfg.fsel  <= FSEL_RST & WMASK;
        end else if (wr_en) begin
            case (sel)
                SEL_DATA: cfg.latch <= wdata;
                SEL_DIR:  cfg.dir   <= wdata & WMASK;
                SEL_FSEL: cfg.fsel  <= wdata & WMASK;
                default:  ;
            endcase
        end
    end

    a_r6_dir_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_DIR) |=> cfg.dir == ($past(wdata) & WMASK));

    a_r6_fsel_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_FSEL) |=> cfg.fsel == ($past(wdata) & WMASK));

    a_r9_none_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_NONE) |=> $stable(cfg));

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg.dir == '0 && cfg.latch == '0));

endmodule

// File: rtl/port_sync.sv
module port_sync
    import port_mux_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] dout
);
    logic [PW-1:0] stage [STAGES];
    logic          hist_ok;

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= din;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) stage[k] <= '0;
            else     stage[k] <= stage[k-1];
        end

        a_r7_chain_shift: assert property (@(posedge clk) disable iff (rst || !hist_ok)
            stage[k] == $past(stage[k-1]));
    end

    always_ff @(posedge clk) begin
        if (rst) hist_ok <= 1'b0;
        else     hist_ok <= 1'b1;
    end

    assign dout = stage[STAGES-1];

endmodule

// File: rtl/port_pin_mux.sv
module port_pin_mux
    import port_mux_pkg::*;
#(
    parameter int IN_ONLY = 2
) (
    input  port_cfg_t     cfg,
    input  pin_drive_t    ded,
    input  logic [PW-1:0] level,
    output pin_drive_t    pad,
    output logic [PW-1:0] rd_data
);
    for (genvar i = 0; i < PW; i++) begin : g_pin
        if (i < IN_ONLY) begin : g_input_only
            assign pad.oe[i]  = 1'b0;
            assign pad.val[i] = 1'b0;
            assign rd_data[i] = level[i];
        end else begin : g_bidir
            logic assigned;
            logic gpio_out;
            assign assigned   = cfg.fsel[i];
            assign gpio_out   = !assigned && cfg.dir[i];
            assign pad.oe[i]  = assigned ? ded.oe[i]  : cfg.dir[i];
            assign pad.val[i] = assigned ? ded.val[i] : cfg.latch[i];
            assign rd_data[i] = gpio_out ? cfg.latch[i] : level[i];
        end
    end

endmodule

// File: rtl/port_func_mux.sv
module port_func_mux
    import port_mux_pkg::*;
#(
    parameter int            IN_ONLY     = 2,
    parameter int            SYNC_STAGES = 2,
    parameter logic [PW-1:0] FSEL_RST    = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] rdata,
    input  logic [PW-1:0] ded_oe,
    input  logic [PW-1:0] ded_out,
    input  logic [PW-1:0] pad_in,
    output logic [PW-1:0] pad_out,
    output logic [PW-1:0] pad_oe,
    output logic [PW-1:0] pin_level,
    output logic          mirq_n,
    output logic          nmirq_n
);
    reg_sel_e      sel;
    port_cfg_t     cfg;
    pin_drive_t    ded;
    pin_drive_t    pad;
    logic [PW-1:0] level;
    logic [PW-1:0] data_rd;

    assign sel     = reg_sel_e'(addr);
    assign ded.oe  = ded_oe;
    assign ded.val = ded_out;

    port_regs #(.IN_ONLY(IN_ONLY), .FSEL_RST(FSEL_RST)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wdata(wdata), .cfg(cfg)
    );

    port_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(pad_in), .dout(level)
    );

    port_pin_mux #(.IN_ONLY(IN_ONLY)) u_mux (
        .cfg(cfg), .ded(ded), .level(level), .pad(pad), .rd_data(data_rd)
    );

    always_comb begin
        case (sel)
            SEL_DATA: rdata = data_rd;
            SEL_DIR:  rdata = cfg.dir;
            SEL_FSEL: rdata = cfg.fsel;
            default:  rdata = '0;
        endcase
    end

    assign pad_oe    = pad.oe;
    assign pad_out   = pad.val;
    assign pin_level = level;
    assign mirq_n    = level[0];
    assign nmirq_n   = level[1];

    a_r4_ded_override: assert property (@(posedge clk) disable iff (rst)
        cfg.fsel[PW-1] |-> (pad_oe[PW-1] == ded_oe[PW-1] && pad_out[PW-1] == ded_out[PW-1]));

    a_r5_input_only_idle: assert property (@(posedge clk) disable iff (rst)
        (ded_oe[0] || ded_oe[1]) |-> (pad_oe[1:0] == 2'b00));

    a_r2_gpio_drive: assert property (@(posedge clk) disable iff (rst)
        (!cfg.fsel[PW-1] && cfg.dir[PW-1]) |-> (pad_oe[PW-1] && pad_out[PW-1] == cfg.latch[PW-1]));

endmodule

// File: tb/tb_port_func_mux.sv
module tb_port_func_mux;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] ded_oe = 8'h00;
    logic [7:0] ded_out = 8'h00;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out, pad_oe, pin_level;
    logic       mirq_n, nmirq_n;

    always #2 clk = ~clk;

    port_func_mux dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ded_oe(ded_oe), .ded_out(ded_out), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pin_level(pin_level), .mirq_n(mirq_n), .nmirq_n(nmirq_n)
    );

    typedef struct {
        string      tag;
        int         kind;
        logic [7:0] exp;
        logic [7:0] mask;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    logic [7:0] m_lat = 8'h00, m_dir = 8'h00, m_fsel = 8'h00;

    function automatic logic [7:0] exp_oe();
        return ((m_fsel & ded_oe) | (~m_fsel & m_dir)) & 8'hFC;
    endfunction

    function automatic logic [7:0] exp_data();
        logic [7:0] o;
        o = ~m_fsel & m_dir & 8'hFC;
        return (o & m_lat) | (~o & pad_in);
    endfunction

    task automatic expect_item(string tag, int kind, logic [7:0] exp, logic [7:0] mask);
        item_t it;
        it.tag = tag; it.kind = kind; it.exp = exp; it.mask = mask;
        q.push_back(it);
    endtask

    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = rdata;
                1: act = pad_oe;
                2: act = pad_out;
                3: act = pin_level;
                default: act = {6'b0, nmirq_n, mirq_n};
            endcase
            checks++;
            if ((act & it.mask) !== (it.exp & it.mask)) begin
                fails++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind,
                         act & it.mask, it.exp & it.mask);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        step();
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
        case (a)
            2'd0: m_lat = d;
            2'd1: m_dir = d & 8'hFC;
            2'd2: m_fsel = d & 8'hFC;
            default: ;
        endcase
    endtask

    task automatic rd_expect(string tag, logic [1:0] a, logic [7:0] exp);
        addr = a;
        expect_item(tag, 0, exp, 8'hFF);
        step();
    endtask

    task automatic set_pads(logic [7:0] p);
        pad_in = p;
        repeat (3) step();
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        rd_expect("R1 dir reset", 2'd1, 8'h00);
        rd_expect("R1 fsel reset", 2'd2, 8'h00);
        expect_item("R1 pad_oe reset", 1, 8'h00, 8'hFF); step();
        rd_expect("R1 latch reset", 2'd0, 8'h00);

        // R6 direction bits 1..0 ignored, R2 outputs
        wr(2'd1, 8'hFF);
        rd_expect("R6 dir readback", 2'd1, 8'hFC);
        wr(2'd0, 8'hA5);
        expect_item("R2 oe all gpio out", 1, exp_oe(), 8'hFF);
        expect_item("R2 pad_out latch", 2, m_lat, 8'hFC);
        expect_item("R5 low pins idle", 1, 8'h00, 8'h03);
        step();
        set_pads(8'h5A);
        rd_expect("R7 data read outputs", 2'd0, exp_data());
        expect_item("R8 irq levels", 4, {6'b0, pad_in[1], pad_in[0]}, 8'h03); step();

        // R3 mixed direction
        wr(2'd1, 8'h0C);
        expect_item("R3 mixed dir oe", 1, 8'h0C, 8'hFF); step();
        set_pads(8'hF3);
        rd_expect("R7 mixed data read", 2'd0, exp_data());

        // R4 dedicated override, R5 with dedicated enables
        ded_oe = 8'hFF; ded_out = 8'h3C;
        wr(2'd2, 8'hFF);
        rd_expect("R6 fsel readback", 2'd2, 8'hFC);
        expect_item("R4 ded oe", 1, 8'hFC, 8'hFF);
        expect_item("R4 ded out", 2, 8'h3C, 8'hFC);
        expect_item("R5 ded oe masked", 1, 8'h00, 8'h03);
        step();
        ded_oe = 8'h55;
        step();
        expect_item("R4 ded oe partial", 1, exp_oe(), 8'hFF); step();
        rd_expect("R7 assigned pins read pad", 2'd0, pad_in);

        // R8 interrupt pins while assigned
        set_pads(8'hF1);
        rd_expect("R8 data bits1..0", 2'd0, pad_in);
        expect_item("R8 irq pair", 4, 8'h01, 8'h03);
        expect_item("R8 pin_level", 3, 8'hF1, 8'hFF); step();
        set_pads(8'hF2);
        expect_item("R8 irq pair swap", 4, 8'h02, 8'h03); step();

        // R7 synchronizer depth
        pad_in = 8'h00;
        repeat (3) step();
        pad_in = 8'h81;
        step();
        expect_item("R7 one edge old", 3, 8'h00, 8'hFF); step();
        expect_item("R7 two edges new", 3, 8'h81, 8'hFF); step();

        // R9 unmapped address
        wr(2'd3, 8'hFF);
        rd_expect("R9 unmapped reads zero", 2'd3, 8'h00);
        rd_expect("R9 dir unchanged", 2'd1, m_dir);
        rd_expect("R9 fsel unchanged", 2'd2, m_fsel);
        rd_expect("R9 latch unchanged", 2'd0, exp_data());

        repeat (2) step();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule